// File: doc/BRIEF.md
# Prefixed Instruction Format Decoder

This block is a purely combinational decoder for the 48-bit and 64-bit prefixed instruction forms. The prefix wraps a standard 32-bit base instruction and adds vector context to it. The decoder rebuilds the base instruction and classifies it by its major opcode, which selects one of eight prefix layouts. From that layout it picks out the extra register-number bits and the vector/scalar flags. It then forms a 7-bit register number for each of the four operand slots.

The decoder also unpacks the layout's packed field, which holds the element type, the predicate or twin predicate, and the sub-vector length. In the 64-bit form it passes on the 12-bit vector-length control field. A single illegal flag collects every reserved encoding. The flag is raised by a reserved layout choice, a reserved bit that is set, a reserved pattern in a packed field, or a vector-length register source of x0. The decode stage of a core instantiates the block and feeds its outputs to register renaming and loop control. The block does not execute anything.

Top module: `pfx_decoder`

## Requirements
- R1: An input whose bits 5:0 are 011111 is the 48-bit form (`is_p48_o`=1). In that form bit 6 is reserved and must be zero. An input whose bits 6:0 are 0111111 is the 64-bit form (`is_p64_o`=1). Any other input raises `illegal_o`, with both form flags at 0.
- R2: `base_o` is {insn[47:18], 2'b11}. In the 48-bit form, bits 63:48 have no effect on any output, and `vlctl_o` is 0.
- R3: `fmt_o` is set from base bits 6:2. LOAD 00000 and LOAD-FP 00001 give 1 (LD). STORE 01000 and STORE-FP 01001 give 2 (ST). OP 01100 and OP-32 01110 give 3 (R). OP-IMM 00100, OP-IMM-32 00110 and JALR 11001 give 4 (I). LUI 01101 and AUIPC 00101 give 5 (U). OP-FP 10100 gives 7 (FI) when base bits 31:27 are 01000, 01011, 11000, 11010, 11100 or 11110, and 6 (FR) otherwise. The four fused multiply-add opcodes 10000 to 10011 give 8 (FR4). Every other opcode, SYSTEM 11100 included, gives 0 and raises `illegal_o`.
- R4: In the 48-bit form, an operand's 6-bit field r is {ext, base field}. The base fields are rd=base[11:7], rs1=base[19:15], rs2=base[24:20] and rs3=base[31:27]. The ext bits are insn[17] for rd (absent in ST), insn[16] for rs1 (absent in U), insn[15] for rs2 (ST, R, FR, FR4 only) and insn[13] for rs3 (FR4 only). An absent ext bit reads as 0. The number is {r[0], r[5:1], 0} for a vector operand and {0, r} for a scalar operand.
- R5: In the 64-bit form, each number is {bit6, ext, base field} whatever the vector flag. Bit6 comes from insn[63] for rd (not ST), insn[62] for rs1 (not U), insn[61] for rs2 (ST, R, FR, FR4) and insn[60] for rs3 (FR4).
- R6: `vec_o` is {rd, rs1, rs2, rs3}. The flags present are vd=insn[14] in LD, I, FI and U; vs2=insn[14] in ST, R, FR and FR4; vs1=insn[13] in LD, ST, R, I, FR and FI; and vs3=insn[12] in FR4. An operand with no flag of its own takes the OR of the flags present. In the 64-bit R and FR layouts, the rd flag is insn[60].
- R7: In FR and FR4, insn[11:7] is read with `pred_o`=bits 4:2 and `svlen_o`=bits 1:0. A value of 001 in bits 4:2 is reserved and raises `illegal_o`.
- R8: In R and U, insn[12:7] gives `elty_o`=bits 5:4, `pred_o`={0, bits 3:2} and `svlen_o`=bits 1:0. A value of 01 in bits 3:2 raises `illegal_o`.
- R9: In LD, ST, I and FI, the 7-bit field is {insn[15], insn[12:7]}, with insn[17] in place of insn[15] for ST. It gives `elty_o`=bits 5:4, `tpred_o`={bit 6, bits 3:2} and `svlen_o`=bits 1:0.
- R10: `signed_o` is 0 for OP and OP-IMM and 1 for OP-32 and OP-IMM-32. For OP-FP with base bits 31:27 of 11000 or 11010, it is the inverse of base bit 20. It is 0 in all other cases.
- R11: A reserved bit that is set raises `illegal_o`. In 48-bit U these bits are insn[16], insn[15] and insn[13]. In 48-bit FR the bit is insn[12]. In the 64-bit form they are insn[63] in ST, insn[62] in U, insn[61] in LD, I, U and FI, and insn[60] in LD, ST, I, U and FI.
- R12: In the 64-bit form, `vlctl_o` is insn[59:48]. A field with bit 11 at 0, bit 0 at 1 and bits 5:1 at zero (register mode naming x0) raises `illegal_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 64 | Prefixed instruction, low bits first |
| is_p48_o | output | 1 | 48-bit form recognised |
| is_p64_o | output | 1 | 64-bit form recognised |
| base_o | output | 32 | Rebuilt base instruction |
| fmt_o | output | 4 | Prefix layout code (0 = reserved) |
| rd_num_o | output | 7 | Destination register number |
| rs1_num_o | output | 7 | First source register number |
| rs2_num_o | output | 7 | Second source register number |
| rs3_num_o | output | 7 | Third source register number |
| vec_o | output | 4 | Vector flags {rd, rs1, rs2, rs3} |
| elty_o | output | 2 | Element type code |
| signed_o | output | 1 | Element signedness |
| pred_o | output | 3 | Single predicate code |
| tpred_o | output | 3 | Twin predicate code |
| svlen_o | output | 2 | Sub-vector length code |
| vlctl_o | output | 12 | Vector-length control field |
| illegal_o | output | 1 | Illegal or reserved encoding |

## Verification
The bench targets the bit rotation applied to odd register numbers in the vector 48-bit case. If the rotation were skipped or applied in the 64-bit form, the register numbers would come out wrong. It also drives inherited flags in every layout, including the 64-bit R case where the rd flag has its own bit. A decoder that always used the OR would mark the wrong destination as a vector. Each reserved pattern is sent next to a neighbouring legal value: the packed-field holes, the per-layout reserved bits in both forms, a reserved bit 6 on the short form, and the x0 vector-length source. A wrong mask would then show up either as a missed illegal flag or as a false one. The bench also checks that the unused top 16 bits of the short form have no effect, and that the fcvt signedness follows base bit 20.

// File: rtl/pfx_decoder.sv
module pfx_decoder (
  input  logic [63:0] insn_i,
  output logic        is_p48_o,
  output logic        is_p64_o,
  output logic [31:0] base_o,
  output logic [3:0]  fmt_o,
  output logic [6:0]  rd_num_o,
  output logic [6:0]  rs1_num_o,
  output logic [6:0]  rs2_num_o,
  output logic [6:0]  rs3_num_o,
  output logic [3:0]  vec_o,
  output logic [1:0]  elty_o,
  output logic        signed_o,
  output logic [2:0]  pred_o,
  output logic [2:0]  tpred_o,
  output logic [1:0]  svlen_o,
  output logic [11:0] vlctl_o,
  output logic        illegal_o
);
  localparam logic [3:0] F_NONE = 4'd0, F_LD = 4'd1, F_ST = 4'd2, F_R = 4'd3, F_I = 4'd4,
                         F_U = 4'd5, F_FR = 4'd6, F_FI = 4'd7, F_FR4 = 4'd8;

  logic [31:0] b;
  logic [4:0]  opc, f5;
  logic        p48, p64, any_form;
  logic [3:0]  fmt;
  logic        is_ld, is_st, is_r, is_i, is_u, is_fr, is_fi, is_fr4;
  logic        x_rd, x_rs1, x_rs2, x_rs3;
  logic        w_rd, w_rs1, w_rs2, w_rs3;
  logic        v_rd, v_rs1, v_rs2, v_rs3;
  logic        pat_bad, bits_bad, vl_bad;
  logic [6:0]  t7;

  assign b        = {insn_i[47:18], 2'b11};
  assign opc      = b[6:2];
  assign f5       = b[31:27];
  assign p48      = insn_i[5:0] == 6'b011111;
  assign p64      = insn_i[6:0] == 7'b0111111;
  assign any_form = p48 | p64;

  always_comb begin
    case (opc)
      5'b00000, 5'b00001:                   fmt = F_LD;
      5'b01000, 5'b01001:                   fmt = F_ST;
      5'b01100, 5'b01110:                   fmt = F_R;
      5'b00100, 5'b00110, 5'b11001:         fmt = F_I;
      5'b01101, 5'b00101:                   fmt = F_U;
      5'b10000, 5'b10001, 5'b10010, 5'b10011: fmt = F_FR4;
      5'b10100: begin
        case (f5)
          5'b01000, 5'b01011, 5'b11000, 5'b11010, 5'b11100, 5'b11110: fmt = F_FI;
          default: fmt = F_FR;
        endcase
      end
      default: fmt = F_NONE;
    endcase
  end

  assign is_ld  = fmt == F_LD;
  assign is_st  = fmt == F_ST;
  assign is_r   = fmt == F_R;
  assign is_i   = fmt == F_I;
  assign is_u   = fmt == F_U;
  assign is_fr  = fmt == F_FR;
  assign is_fi  = fmt == F_FI;
  assign is_fr4 = fmt == F_FR4;

  assign x_rd  = insn_i[17] & ~is_st & (fmt != F_NONE);
  assign x_rs1 = insn_i[16] & ~is_u & (fmt != F_NONE);
  assign x_rs2 = insn_i[15] & (is_st | is_r | is_fr | is_fr4);
  assign x_rs3 = insn_i[13] & is_fr4;

  assign w_rd  = insn_i[63] & ~is_st & (fmt != F_NONE);
  assign w_rs1 = insn_i[62] & ~is_u & (fmt != F_NONE);
  assign w_rs2 = insn_i[61] & (is_st | is_r | is_fr | is_fr4);
  assign w_rs3 = insn_i[60] & is_fr4;

  always_comb begin
    v_rd = 1'b0; v_rs1 = 1'b0; v_rs2 = 1'b0; v_rs3 = 1'b0;
    case (fmt)
      F_LD, F_I, F_FI: begin
        v_rd  = insn_i[14];
        v_rs1 = insn_i[13];
        v_rs2 = insn_i[14] | insn_i[13];
        v_rs3 = insn_i[14] | insn_i[13];
      end
      F_ST: begin
        v_rs1 = insn_i[13];
        v_rs2 = insn_i[14];
        v_rd  = insn_i[14] | insn_i[13];
        v_rs3 = insn_i[14] | insn_i[13];
      end
      F_R, F_FR: begin
        v_rs1 = insn_i[13];
        v_rs2 = insn_i[14];
        v_rd  = p64 ? insn_i[60] : (insn_i[14] | insn_i[13]);
        v_rs3 = insn_i[14] | insn_i[13];
      end
      F_U: begin
        v_rd = insn_i[14]; v_rs1 = insn_i[14]; v_rs2 = insn_i[14]; v_rs3 = insn_i[14];
      end
      F_FR4: begin
        v_rs2 = insn_i[14];
        v_rs3 = insn_i[12];
        v_rd  = insn_i[14] | insn_i[12];
        v_rs1 = insn_i[14] | insn_i[12];
      end
      default: ;
    endcase
  end

  function automatic logic [6:0] regnum(input logic wide, input logic hi6, input logic hi5,
                                        input logic [4:0] lo, input logic vec);
    if (wide)     return {hi6, hi5, lo};
    else if (vec) return {lo[0], hi5, lo[4:1], 1'b0};
    else          return {1'b0, hi5, lo};
  endfunction

  assign rd_num_o  = regnum(p64, w_rd,  x_rd,  b[11:7],  v_rd);
  assign rs1_num_o = regnum(p64, w_rs1, x_rs1, b[19:15], v_rs1);
  assign rs2_num_o = regnum(p64, w_rs2, x_rs2, b[24:20], v_rs2);
  assign rs3_num_o = regnum(p64, w_rs3, x_rs3, b[31:27], v_rs3);
  assign vec_o     = {v_rd, v_rs1, v_rs2, v_rs3};

  assign t7 = {is_st ? insn_i[17] : insn_i[15], insn_i[12:7]};

  always_comb begin
    elty_o = 2'b00; pred_o = 3'b000; tpred_o = 3'b000; svlen_o = 2'b00; pat_bad = 1'b0;
    case (fmt)
      F_FR, F_FR4: begin
        pred_o  = insn_i[11:9];
        svlen_o = insn_i[8:7];
        pat_bad = insn_i[11:9] == 3'b001;
      end
      F_R, F_U: begin
        elty_o  = insn_i[12:11];
        pred_o  = {1'b0, insn_i[10:9]};
        svlen_o = insn_i[8:7];
        pat_bad = insn_i[10:9] == 2'b01;
      end
      F_LD, F_ST, F_I, F_FI: begin
        elty_o  = t7[5:4];
        tpred_o = {t7[6], t7[3:2]};
        svlen_o = t7[1:0];
      end
      default: ;
    endcase
  end

  always_comb begin
    case (opc)
      5'b01100, 5'b00100: signed_o = 1'b0;
      5'b01110, 5'b00110: signed_o = 1'b1;
      5'b10100:           signed_o = (f5 == 5'b11000 || f5 == 5'b11010) ? ~b[20] : 1'b0;
      default:            signed_o = 1'b0;
    endcase
  end

  assign bits_bad = (p48 & insn_i[6])
                  | (p48 & is_u & (insn_i[16] | insn_i[15] | insn_i[13]))
                  | (p48 & is_fr & insn_i[12])
                  | (p64 & is_st & insn_i[63])
                  | (p64 & is_u & insn_i[62])
                  | (p64 & (is_ld | is_i | is_u | is_fi) & insn_i[61])
                  | (p64 & (is_ld | is_st | is_i | is_u | is_fi) & insn_i[60]);

  assign vlctl_o = p64 ? insn_i[59:48] : 12'h000;
  assign vl_bad  = p64 & ~insn_i[59] & insn_i[48] & (insn_i[53:49] == 5'd0);

  assign is_p48_o  = p48;
  assign is_p64_o  = p64;
  assign base_o    = b;
  assign fmt_o     = fmt;
  assign illegal_o = ~any_form | (fmt == F_NONE) | pat_bad | bits_bad | vl_bad;
endmodule

module pfx_decoder_chk (
  input logic        is_p48_o,
  input logic        is_p64_o,
  input logic [31:0] base_o,
  input logic [3:0]  fmt_o,
  input logic [6:0]  rd_num_o,
  input logic [6:0]  rs1_num_o,
  input logic [3:0]  vec_o,
  input logic [2:0]  pred_o,
  input logic [11:0] vlctl_o,
  input logic        illegal_o
);
  always_comb begin
    AST_UNKNOWN_ILLEGAL: assert (is_p48_o || is_p64_o || illegal_o);                 // R1
    AST_SHORT_NO_VLCTL: assert (!is_p48_o || vlctl_o == 12'h000);                    // R2
    AST_NOFMT_ILLEGAL: assert (fmt_o != 4'd0 || illegal_o);                          // R3
    AST_VEC_EVEN: assert (!(is_p48_o && fmt_o != 4'd0 && vec_o[3]) || !rd_num_o[0]);  // R4
    AST_SCALAR_NARROW: assert (!(is_p48_o && !vec_o[2]) || !rs1_num_o[6]);           // R4
    AST_WIDE_LOW: assert (!is_p64_o || rs1_num_o[4:0] == base_o[19:15]);             // R5
    AST_PRED_RSVD: assert (pred_o != 3'b001 || illegal_o);                           // R7
  end
endmodule

bind pfx_decoder pfx_decoder_chk u_chk (
  .is_p48_o(is_p48_o), .is_p64_o(is_p64_o), .base_o(base_o), .fmt_o(fmt_o),
  .rd_num_o(rd_num_o), .rs1_num_o(rs1_num_o), .vec_o(vec_o), .pred_o(pred_o),
  .vlctl_o(vlctl_o), .illegal_o(illegal_o)
);

// File: tb/tb_pfx_decoder.sv
module tb_pfx_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [63:0] insn;
  logic        is_p48, is_p64, signed_b, illegal;
  logic [31:0] base;
  logic [3:0]  fmt, vec;
  logic [6:0]  rd_n, rs1_n, rs2_n, rs3_n;
  logic [1:0]  elty, svlen;
  logic [2:0]  pred, tpred;
  logic [11:0] vlctl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef enum int {S_ILL, S_FMT, S_BASE, S_RD, S_RS1, S_RS2, S_RS3, S_VEC,
                    S_ELTY, S_SGN, S_PRED, S_TPRED, S_SVLEN, S_VL, S_FORM} sel_t;
  typedef struct { sel_t sel; logic [31:0] exp; string tag; } item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pfx_decoder dut (
    .insn_i(insn), .is_p48_o(is_p48), .is_p64_o(is_p64), .base_o(base), .fmt_o(fmt),
    .rd_num_o(rd_n), .rs1_num_o(rs1_n), .rs2_num_o(rs2_n), .rs3_num_o(rs3_n),
    .vec_o(vec), .elty_o(elty), .signed_o(signed_b), .pred_o(pred), .tpred_o(tpred),
    .svlen_o(svlen), .vlctl_o(vlctl), .illegal_o(illegal)
  );

  function automatic logic [63:0] p48f(input logic [31:0] b, input logic [10:0] hi);
    return {16'h0000, b[31:2], hi, 7'b0011111};
  endfunction

  function automatic logic [63:0] p64f(input logic [3:0] top, input logic [11:0] vl,
                                       input logic [31:0] b, input logic [10:0] hi);
    return {top, vl, b[31:2], hi, 7'b0111111};
  endfunction

  function automatic logic [31:0] actual(input sel_t s);
    case (s)
      S_ILL:   return {31'd0, illegal};
      S_FMT:   return {28'd0, fmt};
      S_BASE:  return base;
      S_RD:    return {25'd0, rd_n};
      S_RS1:   return {25'd0, rs1_n};
      S_RS2:   return {25'd0, rs2_n};
      S_RS3:   return {25'd0, rs3_n};
      S_VEC:   return {28'd0, vec};
      S_ELTY:  return {30'd0, elty};
      S_SGN:   return {31'd0, signed_b};
      S_PRED:  return {29'd0, pred};
      S_TPRED: return {29'd0, tpred};
      S_SVLEN: return {30'd0, svlen};
      S_VL:    return {20'd0, vlctl};
      default: return {30'd0, is_p48, is_p64};
    endcase
  endfunction

  task automatic drive(input logic [63:0] v);
    @(posedge clk);
    #1 insn = v;
  endtask

  task automatic expect_f(input sel_t s, input logic [31:0] e, input string tag);
    item_t it;
    it.sel = s; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] a;
      it = q.pop_front();
      a = actual(it.sel);
      checks++;
      if (a !== it.exp) begin
        errors++;
        $display("FAIL %s field=%s actual=%h expected=%h", it.tag, it.sel.name(), a, it.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [31:0] ADD_A  = 32'h002081B3;
  localparam logic [31:0] ADD_B  = 32'h005081B3;
  localparam logic [31:0] ADDIW  = 32'h0073029B;
  localparam logic [31:0] LUI7   = 32'h123453B7;
  localparam logic [31:0] FMADD  = 32'h203100C3;
  localparam logic [31:0] FCVTW  = 32'hC00100D3;
  localparam logic [31:0] FCVTWU = 32'hC01100D3;
  localparam logic [31:0] FADD   = 32'h003100D3;
  localparam logic [31:0] SW     = 32'h0050A423;
  localparam logic [31:0] LW     = 32'h00012203;

  initial begin
    insn = 64'h0;
    // R1 idle value: no form recognised
    drive(64'h0);
    expect_f(S_ILL, 1, "R1"); expect_f(S_FORM, 0, "R1");

    // R2 R3 R4 plain scalar add
    drive(p48f(ADD_A, 11'h000));
    expect_f(S_FORM, 2'b10, "R1"); expect_f(S_ILL, 0, "R3"); expect_f(S_FMT, 3, "R3");
    expect_f(S_BASE, ADD_A, "R2"); expect_f(S_RD, 3, "R4"); expect_f(S_RS1, 1, "R4");
    expect_f(S_RS2, 2, "R4"); expect_f(S_VEC, 0, "R6"); expect_f(S_SGN, 0, "R10");
    expect_f(S_VL, 0, "R2");

    // R2 top bits ignored in 48-bit form
    drive(p48f(ADD_A, 11'h000) | 64'hFFFF_0000_0000_0000);
    expect_f(S_ILL, 0, "R2"); expect_f(S_RD, 3, "R2"); expect_f(S_VL, 0, "R2");
    expect_f(S_VEC, 0, "R2");

    // R1 reserved bit 6 in 48-bit form
    drive(p48f(ADD_A, 11'h000) | 64'h40);
    expect_f(S_FORM, 2'b10, "R1"); expect_f(S_ILL, 1, "R1");

    // R4 R6 R8 vector rotation and inherited rd flag
    drive(p48f(ADD_B, 11'h6AB));
    expect_f(S_ILL, 0, "R8"); expect_f(S_RD, 7'h62, "R4"); expect_f(S_RS1, 33, "R4");
    expect_f(S_RS2, 7'h44, "R4"); expect_f(S_VEC, 4'hB, "R6"); expect_f(S_ELTY, 2, "R8");
    expect_f(S_PRED, 3'b010, "R8"); expect_f(S_SVLEN, 3, "R8");

    // R8 reserved pattern
    drive(p48f(ADD_A, 11'h004));
    expect_f(S_ILL, 1, "R8"); expect_f(S_FMT, 3, "R8");

    // R9 R10 twin-predicate field on addiw
    drive(p48f(ADDIW, 11'h19E));
    expect_f(S_FMT, 4, "R3"); expect_f(S_ILL, 0, "R9"); expect_f(S_SGN, 1, "R10");
    expect_f(S_TPRED, 7, "R9"); expect_f(S_ELTY, 1, "R9"); expect_f(S_SVLEN, 2, "R9");
    expect_f(S_RD, 7'h44, "R4"); expect_f(S_RS1, 6, "R4"); expect_f(S_VEC, 4'hB, "R6");

    // R11 reserved bit in U and legal U
    drive(p48f(LUI7, 11'h200));
    expect_f(S_FMT, 5, "R3"); expect_f(S_ILL, 1, "R11");
    drive(p48f(LUI7, 11'h000));
    expect_f(S_ILL, 0, "R11"); expect_f(S_RD, 7, "R4");

    // R3 reserved branch and system
    drive(p48f(32'h00000063, 11'h000));
    expect_f(S_FMT, 0, "R3"); expect_f(S_ILL, 1, "R3");
    drive(p48f(32'h00000073, 11'h000));
    expect_f(S_FMT, 0, "R3"); expect_f(S_ILL, 1, "R3");

    // R4 R6 R7 fused multiply-add
    drive(p48f(FMADD, 11'h07B));
    expect_f(S_FMT, 8, "R3"); expect_f(S_ILL, 0, "R7"); expect_f(S_RS3, 7'h24, "R4");
    expect_f(S_RD, 7'h40, "R4"); expect_f(S_VEC, 4'hD, "R6"); expect_f(S_PRED, 6, "R7");
    expect_f(S_SVLEN, 3, "R7");
    drive(p48f(FMADD, 11'h006));
    expect_f(S_ILL, 1, "R7");

    // R10 R3 conversions, R11 FR reserved bit
    drive(p48f(FCVTW, 11'h000));
    expect_f(S_FMT, 7, "R3"); expect_f(S_SGN, 1, "R10");
    drive(p48f(FCVTWU, 11'h000));
    expect_f(S_SGN, 0, "R10");
    drive(p48f(FADD, 11'h000));
    expect_f(S_FMT, 6, "R3"); expect_f(S_ILL, 0, "R11");
    drive(p48f(FADD, 11'h020));
    expect_f(S_ILL, 1, "R11");

    // R9 store twin predicate from bit 17
    drive(p48f(SW, 11'h588));
    expect_f(S_FMT, 2, "R3"); expect_f(S_ILL, 0, "R9"); expect_f(S_TPRED, 6, "R9");
    expect_f(S_RS2, 7'h64, "R4"); expect_f(S_VEC, 4'hB, "R6");

    drive(p48f(LW, 11'h000));
    expect_f(S_FMT, 1, "R3"); expect_f(S_ILL, 0, "R3");

    // R5 wide register numbers, no rotation
    drive(p64f(4'b1110, 12'h000, ADD_B, 11'h080));
    expect_f(S_FORM, 2'b01, "R1"); expect_f(S_ILL, 0, "R5"); expect_f(S_RD, 7'h43, "R5");
    expect_f(S_RS1, 7'h41, "R5"); expect_f(S_RS2, 7'h45, "R5"); expect_f(S_VEC, 4'b0011, "R6");

    // R6 own rd flag in 64-bit R
    drive(p64f(4'b0001, 12'h000, ADD_B, 11'h000));
    expect_f(S_VEC, 4'b1000, "R6"); expect_f(S_RD, 3, "R5");

    // R11 wide reserved bit in U
    drive(p64f(4'b0100, 12'h000, LUI7, 11'h000));
    expect_f(S_ILL, 1, "R11");
    drive(p64f(4'b1000, 12'h000, LUI7, 11'h000));
    expect_f(S_ILL, 0, "R11"); expect_f(S_RD, 7'h47, "R5");

    // R12 vector-length control
    drive(p64f(4'b0000, 12'h001, ADD_B, 11'h000));
    expect_f(S_ILL, 1, "R12"); expect_f(S_VL, 12'h001, "R12");
    drive(p64f(4'b0000, 12'h003, ADD_B, 11'h000));
    expect_f(S_ILL, 0, "R12"); expect_f(S_VL, 12'h003, "R12");
    drive(p64f(4'b0000, 12'h803, ADD_B, 11'h000));
    expect_f(S_ILL, 0, "R12"); expect_f(S_VL, 12'h803, "R12");

    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule